// File: doc/BRIEF.md
# Multi-Job Local Barrier Unit

This block gives a cooperative job scheduler a set of independent rendezvous points. A job that reaches a synchronisation point presents its job index, the barrier it wants and the number of jobs expected at that barrier. The unit marks the job as blocked in a per-job vector. When the last expected job arrives, every recorded participant is unblocked in one cycle and the barrier returns to its empty state, ready for reuse.

Several arrival lanes share one request port. Within a cycle the lanes are applied one after another in lane-index order, so each lane sees the state that the lower-numbered lanes left behind. Arrivals at different barriers in the same cycle therefore all take effect. Arrivals at the same barrier resolve as if they had come in lane order. The scheduler reads the blocked vector to decide which jobs may run. A one-cycle release mask reports which barriers matured, and two one-cycle error pulses report arrivals that were rejected.

Top module: `lbar_unit`

## Requirements
- R1: After reset every bit of `job_blocked` is 0 and `bar_release`, `err_dup` and `err_count` are all 0.
- R2: An accepted arrival with a participant count of 2 or more that does not complete its barrier sets `job_blocked[job]` in the cycle after the arrival.
- R3: The arrival that brings the number of distinct arrivals at a barrier up to the participant count clears the blocked bits of all jobs recorded at that barrier, including the arriving job, in the cycle after the arrival. In that same cycle `bar_release[id]` is 1 for exactly one cycle. No participant is unblocked earlier.
- R4: After it matures, a barrier holds no arrivals. It can be reused at once, including with a different participant count, and no error is raised.
- R5: There are `NUM_BARRIERS` (default 16) barriers, with ids 0 to 15. Maturing one barrier leaves the jobs waiting at every other barrier blocked.
- R6: An arrival with a participant count of 0 or 1 pulses `bar_release[id]` in the next cycle. It blocks no job and is not recorded at the barrier.
- R7: An arrival from a job that is already recorded at the same unmatured barrier pulses `err_dup` in the next cycle. It is not counted again, so one further distinct job is still needed.
- R8: An arrival whose count differs from the count recorded for a barrier that already holds arrivals pulses `err_count` in the next cycle. The arrival is rejected: it is not counted and its job is not blocked.
- R9: When several lanes are valid in one cycle, they are applied in order from lane 0 upward. Lanes at different barriers are all accepted. Two lanes at the same barrier behave exactly as if they had arrived one after the other in lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | NUM_LANES | Per-lane arrival strobe |
| arr_job | input | NUM_LANES x JOB_W | Per-lane job index |
| arr_bar | input | NUM_LANES x BAR_W | Per-lane barrier id |
| arr_need | input | NUM_LANES x 8 | Per-lane participant count |
| job_blocked | output | NUM_JOBS | One bit per job: 1 while the job waits at a barrier |
| bar_release | output | NUM_BARRIERS | One-cycle pulse for each barrier that matured or was passed trivially |
| err_dup | output | 1 | One-cycle pulse for a repeated arrival by the same job |
| err_count | output | 1 | One-cycle pulse for an arrival with a conflicting participant count |

## Verification
Every output is registered. The effect of an arrival presented during cycle N is visible after the clock edge that ends cycle N, and the pulses drop again one edge later. The bench drives each arrival on a falling edge and removes it on the next falling edge. At that same falling edge it samples the blocked vector, the release mask and both error pulses, so every result is compared exactly one register stage after its stimulus. The next idle cycle then confirms that the pulses are gone.

// File: rtl/lbar_pkg.sv
package lbar_pkg;
    // Width of the participant count carried with every arrival
    localparam int unsigned NEED_W = 8;
    typedef logic [NEED_W-1:0] need_t;
endpackage

// File: rtl/lbar_unit.sv
module lbar_unit
    import lbar_pkg::*;
#(
    parameter int unsigned NUM_JOBS     = 32,
    parameter int unsigned NUM_BARRIERS = 16,
    parameter int unsigned NUM_LANES    = 2,
    localparam int unsigned JOB_W = (NUM_JOBS > 1) ? $clog2(NUM_JOBS) : 1,
    localparam int unsigned BAR_W = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_LANES-1:0]                arr_valid,
    input  logic [NUM_LANES-1:0][JOB_W-1:0]     arr_job,
    input  logic [NUM_LANES-1:0][BAR_W-1:0]     arr_bar,
    input  logic [NUM_LANES-1:0][NEED_W-1:0]    arr_need,
    output logic [NUM_JOBS-1:0]                 job_blocked,
    output logic [NUM_BARRIERS-1:0]             bar_release,
    output logic                                err_dup,
    output logic                                err_count
);

    typedef struct packed {
        logic [NUM_BARRIERS-1:0][NEED_W-1:0]   cnt;
        logic [NUM_BARRIERS-1:0][NEED_W-1:0]   need;
        logic [NUM_BARRIERS-1:0][NUM_JOBS-1:0] member;
        logic [NUM_JOBS-1:0]                   blocked;
        logic [NUM_BARRIERS-1:0]               rel;
        logic                                  dup;
        logic                                  mis;
    } state_t;

    state_t st_d, st_q;

    // Lanes are folded into the next state in index order (fixed priority)
    always_comb begin
        logic [BAR_W-1:0] b;
        logic [JOB_W-1:0] j;
        need_t            n;
        st_d     = st_q;
        st_d.rel = '0;
        st_d.dup = 1'b0;
        st_d.mis = 1'b0;
        b = '0;
        j = '0;
        n = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (arr_valid[l]) begin
                b = arr_bar[l];
                j = arr_job[l];
                n = arr_need[l];
                if (n <= need_t'(1)) begin
                    st_d.rel[b] = 1'b1;
                end else if (st_d.member[b][j]) begin
                    st_d.dup = 1'b1;
                end else if (st_d.cnt[b] != '0 && st_d.need[b] != n) begin
                    st_d.mis = 1'b1;
                end else if (st_d.cnt[b] + need_t'(1) == n) begin
                    st_d.blocked    = st_d.blocked & ~st_d.member[b];
                    st_d.blocked[j] = 1'b0;
                    st_d.member[b]  = '0;
                    st_d.cnt[b]     = '0;
                    st_d.rel[b]     = 1'b1;
                end else begin
                    st_d.cnt[b]       = st_d.cnt[b] + need_t'(1);
                    st_d.need[b]      = n;
                    st_d.member[b][j] = 1'b1;
                    st_d.blocked[j]   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign job_blocked = st_q.blocked;
    assign bar_release = st_q.rel;
    assign err_dup     = st_q.dup;
    assign err_count   = st_q.mis;

    // ---------------- assertions ----------------
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2: a blocked bit only rises after an arrival
    a_r2_block_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ((job_blocked & ~$past(job_blocked)) != '0) |-> $past(arr_valid != '0));

    // R3: a release only follows an arrival
    a_r3_release_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && (bar_release != '0) |-> $past(arr_valid != '0));

    // R6: a lone trivial arrival never changes its job's blocked bit and releases its barrier
    a_r6_trivial_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid == NUM_LANES'(1)) && (arr_need[0] <= need_t'(1))
        |=> (job_blocked[$past(arr_job[0])] == $past(job_blocked[arr_job[0]]))
            && bar_release[$past(arr_bar[0])]);

    // R7, R8: error pulses only follow an arrival
    a_r7_dup_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && err_dup |-> $past(arr_valid != '0));
    a_r8_count_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && err_count |-> $past(arr_valid != '0));

    // R3: a barrier never holds as many arrivals as it needs
    for (genvar g = 0; g < NUM_BARRIERS; g++) begin : g_chk
        a_r3_count_below_need: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cnt[g] != '0) |-> (st_q.cnt[g] < st_q.need[g]));
    end

endmodule

// File: tb/lbar_unit_test.sv
module lbar_unit_test;
    localparam int NJ = 32;
    localparam int NB = 16;
    localparam int NL = 2;
    localparam int JW = 5;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0]          arr_valid;
    logic [NL-1:0][JW-1:0]  arr_job;
    logic [NL-1:0][BW-1:0]  arr_bar;
    logic [NL-1:0][7:0]     arr_need;
    logic [NJ-1:0]          job_blocked;
    logic [NB-1:0]          bar_release;
    logic                   err_dup, err_count;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lbar_unit #(.NUM_JOBS(NJ), .NUM_BARRIERS(NB), .NUM_LANES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_job(arr_job),
        .arr_bar(arr_bar), .arr_need(arr_need), .job_blocked(job_blocked),
        .bar_release(bar_release), .err_dup(err_dup), .err_count(err_count));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive up to two lanes for one cycle; returns at the falling edge where results are due
    task automatic arrive2(input logic v0, input int j0, input int b0, input int n0,
                           input logic v1, input int j1, input int b1, input int n1);
        @(negedge clk);
        arr_valid   = {v1, v0};
        arr_job[0]  = JW'(j0); arr_bar[0] = BW'(b0); arr_need[0] = 8'(n0);
        arr_job[1]  = JW'(j1); arr_bar[1] = BW'(b1); arr_need[1] = 8'(n1);
        @(negedge clk);
        arr_valid = '0;
    endtask

    task automatic arrive(input int j, input int b, input int n);
        arrive2(1'b1, j, b, n, 1'b0, 0, 0, 0);
    endtask

    task automatic expect_out(input string tag, input logic [31:0] bl, input logic [15:0] rel,
                              input logic dup, input logic mis);
        chk({tag, " blocked"}, job_blocked, bl);
        chk({tag, " release"}, 32'(bar_release), 32'(rel));
        chk({tag, " dup"}, 32'(err_dup), 32'(dup));
        chk({tag, " count"}, 32'(err_count), 32'(mis));
    endtask

    task automatic t_reset;
        expect_out("R1 reset", 32'h0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic t_basic;
        arrive(1, 3, 3);  expect_out("R2 first", 32'h2, 16'h0, 0, 0);
        arrive(2, 3, 3);  expect_out("R2 second", 32'h6, 16'h0, 0, 0);
        arrive(5, 3, 3);  expect_out("R3 mature", 32'h0, 16'h0008, 0, 0);
        @(negedge clk);   expect_out("R3 pulse width", 32'h0, 16'h0, 0, 0);
    endtask

    task automatic t_reuse;
        arrive(7, 3, 2);  expect_out("R4 reuse new count", 32'h80, 16'h0, 0, 0);
        arrive(8, 3, 2);  expect_out("R4 reuse mature", 32'h0, 16'h0008, 0, 0);
    endtask

    task automatic t_independent;
        arrive(1, 0, 2);  expect_out("R5 bar0", 32'h2, 16'h0, 0, 0);
        arrive(2, 15, 2); expect_out("R5 bar15", 32'h6, 16'h0, 0, 0);
        arrive(3, 0, 2);  expect_out("R5 bar0 only", 32'h4, 16'h0001, 0, 0);
        arrive(4, 15, 2); expect_out("R5 bar15 done", 32'h0, 16'h8000, 0, 0);
    endtask

    task automatic t_trivial;
        arrive(20, 9, 1); expect_out("R6 count one", 32'h0, 16'h0200, 0, 0);
        arrive(21, 9, 0); expect_out("R6 count zero", 32'h0, 16'h0200, 0, 0);
        arrive(22, 9, 2); expect_out("R6 not recorded", 32'h0040_0000, 16'h0, 0, 0);
        arrive(23, 9, 2); expect_out("R6 then mature", 32'h0, 16'h0200, 0, 0);
    endtask

    task automatic t_dup;
        arrive(9, 4, 2);  expect_out("R7 first", 32'h200, 16'h0, 0, 0);
        arrive(9, 4, 2);  expect_out("R7 repeat", 32'h200, 16'h0, 1, 0);
        arrive(10, 4, 2); expect_out("R7 needs one more", 32'h0, 16'h0010, 0, 0);
    endtask

    task automatic t_mismatch;
        arrive(11, 5, 3); expect_out("R8 first", 32'h800, 16'h0, 0, 0);
        arrive(12, 5, 4); expect_out("R8 conflict", 32'h800, 16'h0, 0, 1);
        arrive(12, 5, 3); expect_out("R8 retry", 32'h1800, 16'h0, 0, 0);
        arrive(13, 5, 3); expect_out("R8 mature", 32'h0, 16'h0020, 0, 0);
    endtask

    task automatic t_lanes;
        arrive2(1, 14, 6, 2, 1, 15, 6, 2);
        expect_out("R9 same barrier", 32'h0, 16'h0040, 0, 0);
        arrive2(1, 16, 7, 2, 1, 17, 8, 2);
        expect_out("R9 two barriers", 32'h0003_0000, 16'h0, 0, 0);
        arrive2(1, 18, 7, 2, 1, 19, 8, 2);
        expect_out("R9 two releases", 32'h0, 16'h0180, 0, 0);
        arrive2(1, 24, 10, 2, 1, 24, 10, 2);
        expect_out("R9 lane order dup", 32'h0100_0000, 16'h0, 1, 0);
        arrive(25, 10, 2);
        expect_out("R9 close", 32'h0, 16'h0400, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        arr_valid = '0;
        arr_job = '0;
        arr_bar = '0;
        arr_need = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reuse();
        t_independent();
        t_trivial();
        t_dup();
        t_mismatch();
        t_lanes();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule